// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block turns a parallel word into a serial bit stream. While the shift/load select is low, every stage of the register copies its own parallel input. After the select returns high, each rising edge of a gated external clock moves the contents one stage toward the serial output. A serial input fills the stage at the far end. The serial output is also provided inverted.

The external clock and the clock-inhibit pins act as one interchangeable pair. Their OR forms the effective clock, so a rising edge on either pin can trigger a shift. All pins are asynchronous to the free-running system clock. They pass through a multi-stage synchronizer, and a shift fires when the controller sees the synchronized OR change from 0 to 1. Loading has priority over shifting. Any edge that arrives while a load is active is consumed and not remembered.

Top module: `piso_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage, so `serOut` reads 0 and `serOutN` reads 1.
- R2: While `shLdN` is low, stage i holds `parIn[i]`, and it keeps following `parIn` as long as the load lasts. `serOut` shows the last stage, `parIn[WIDTH-1]`.
- R3: While `shLdN` is low, edges on `extClk` or `clkInhibit` and changes on `serIn` have no effect. No shift is queued for after the load ends.
- R4: With `shLdN` high and `clkInhibit` low, a rising edge of `extClk` shifts the register once. Stage 0 takes `serIn`, each stage i takes the old stage i-1, and the old last stage is discarded.
- R5: With `extClk` low, a rising edge of `clkInhibit` produces exactly one shift, the same as R4.
- R6: Nothing shifts when `clkInhibit` rises while `extClk` is high, or when either pin falls while the other is high. Without a load or shift, the stages hold their values.
- R7: `serOutN` is always the complement of `serOut`.
- R8: A pin change made between system clock edges shows at `serOut` on the (SYNC_STAGES+1)-th rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| shLdN | input | 1 | Low loads the parallel word, high allows shifting |
| extClk | input | 1 | External shift clock, asynchronous |
| clkInhibit | input | 1 | Clock inhibit, interchangeable with `extClk` |
| serIn | input | 1 | Serial bit entering stage 0 on a shift |
| parIn | input | WIDTH | Parallel word, bit i feeds stage i |
| serOut | output | 1 | Last stage of the register |
| serOutN | output | 1 | Complement of `serOut` |

## Verification
The bench builds the block with its default parameters: WIDTH of 8 and SYNC_STAGES of 2. With these values a full word drains in eight gated-clock pulses, so every stage is seen at the output. The three-edge latency of R8 is short enough to check edge by edge. Directed sequences drive edges on each pin alone and in the risky ordering where inhibit rises while the clock is high. They also hold loads across clock pulses and change the parallel word during a load. The serial output is compared against a bench model after every step.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;    // copy parallel word into the stages
    logic shift;   // advance one stage toward the output
    logic serBit;  // synchronized serial bit for stage 0
  } strobe_t;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int Depth = (STAGES < 2) ? 2 : STAGES;

  logic [Depth-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < Depth; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < Depth; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[Depth-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    shLdN,
  input  logic    extClk,
  input  logic    clkInhibit,
  input  logic    serIn,
  output strobe_t strobe
);
  localparam int PinCount = 4;
  // bit order: {serIn, shLdN, clkInhibit, extClk}; shLdN idles high
  localparam logic [PinCount-1:0] PinRst = 4'b0100;

  logic [PinCount-1:0] pinRaw, pinSync;
  logic gatedNow, gatedPrev;

  assign pinRaw = {serIn, shLdN, clkInhibit, extClk};

  piso_sync #(
    .WIDTH(PinCount),
    .STAGES(SYNC_STAGES),
    .RST_VAL(PinRst)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .asyncIn(pinRaw),
    .syncOut(pinSync)
  );

  assign gatedNow = pinSync[0] | pinSync[1];

  // edge memory is updated during load too, so no edge is held over
  always_ff @(posedge clk) begin
    if (rst) gatedPrev <= 1'b0;
    else     gatedPrev <= gatedNow;
  end

  always_comb begin
    strobe.load   = ~pinSync[2];
    strobe.shift  = pinSync[2] & gatedNow & ~gatedPrev;
    strobe.serBit = pinSync[3];
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ
);
  always_ff @(posedge clk) begin
    if (rst)               stageQ <= '0;
    else if (strobe.load)  stageQ <= parIn;
    else if (strobe.shift) stageQ <= {stageQ[WIDTH-2:0], strobe.serBit};
  end
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shLdN,
  input  logic             extClk,
  input  logic             clkInhibit,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN
);
  strobe_t          strobe;
  logic [WIDTH-1:0] stageQ;

  piso_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk),
    .rst(rst),
    .shLdN(shLdN),
    .extClk(extClk),
    .clkInhibit(clkInhibit),
    .serIn(serIn),
    .strobe(strobe)
  );

  piso_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .parIn(parIn),
    .stageQ(stageQ)
  );

  assign serOut  = stageQ[WIDTH-1];
  assign serOutN = ~stageQ[WIDTH-1];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] stageQ,
  input strobe_t          strobe,
  input logic             serOut,
  input logic             serOutN
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stageQ == '0));

  a_r2_load_copy: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (stageQ == $past(parIn)));

  a_r4_shift_step: assert property (@(posedge clk) disable iff (rst)
    strobe.shift |=> (stageQ == {$past(stageQ[WIDTH-2:0]), $past(strobe.serBit)}));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.shift) |=> $stable(stageQ));

  a_r7_complement: assert property (@(posedge clk) disable iff (rst)
    (serOutN == ~serOut) && (serOut == stageQ[WIDTH-1]));
endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk),
  .rst(rst),
  .parIn(parIn),
  .stageQ(stageQ),
  .strobe(strobe),
  .serOut(serOut),
  .serOutN(serOutN)
);

// File: tb/piso_shifter_tb.sv
module piso_shifter_tb_top;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shLdN = 1'b1, extClk = 1'b0, clkInhibit = 1'b0, serIn = 1'b0;
  logic [WIDTH-1:0] parIn = '0;
  logic serOut, serOutN;

  logic [WIDTH-1:0] model = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  piso_shifter #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .shLdN(shLdN), .extClk(extClk),
    .clkInhibit(clkInhibit), .serIn(serIn), .parIn(parIn),
    .serOut(serOut), .serOutN(serOutN)
  );

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // serial output against the model, plus R7 on the complement
  task automatic checkOut(string req);
    checkBit(req, serOut, model[WIDTH-1]);
    checkBit("R7", serOutN, ~model[WIDTH-1]);
  endtask

  task automatic doLoad(logic [WIDTH-1:0] val);
    parIn = val; shLdN = 1'b0; settle();
    shLdN = 1'b1; settle();
    model = val;
  endtask

  task automatic pulseClk(logic bitIn);
    serIn = bitIn; extClk = 1'b1; settle();
    extClk = 1'b0; settle();
    model = {model[WIDTH-2:0], bitIn};
  endtask

  task automatic pulseInh(logic bitIn);
    serIn = bitIn; clkInhibit = 1'b1; settle();
    clkInhibit = 1'b0; settle();
    model = {model[WIDTH-2:0], bitIn};
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model = '0;
    checkOut("R1");
  endtask

  task automatic testLoadShift();
    doLoad(8'b1011_0010);
    checkOut("R2");
    for (int i = 0; i < WIDTH; i++) begin
      pulseClk(1'b0);
      checkOut("R4");
    end
  endtask

  task automatic testSerialFill();
    logic [WIDTH-1:0] pat = 8'hC5;
    for (int i = WIDTH - 1; i >= 0; i--) pulseClk(pat[i]);
    for (int i = 0; i < WIDTH; i++) begin
      checkOut("R4");
      pulseClk(1'b1);
    end
  endtask

  task automatic testInhibitEdge();
    doLoad(8'h55);
    for (int i = 0; i < 4; i++) begin
      pulseInh(i[0]);
      checkOut("R5");
    end
  endtask

  task automatic testInhibitWhileHigh();
    doLoad(8'hC0);
    serIn = 1'b0;
    extClk = 1'b1; settle();                        // legal shift
    model = {model[WIDTH-2:0], 1'b0};
    checkOut("R4");
    clkInhibit = 1'b1; settle(); checkOut("R6");    // inhibit up while clock high
    extClk = 1'b0; settle(); checkOut("R6");        // clock falls under inhibit
    clkInhibit = 1'b0; settle(); checkOut("R6");
    pulseClk(1'b0);
    checkOut("R6");
  endtask

  task automatic testLoadOverride();
    parIn = 8'h7F; shLdN = 1'b0; settle();
    model = 8'h7F;
    checkOut("R2");
    serIn = 1'b1; extClk = 1'b1; settle(); checkOut("R3");
    extClk = 1'b0; clkInhibit = 1'b1; settle(); checkOut("R3");
    clkInhibit = 1'b0; settle();
    parIn = 8'h80; settle();
    model = 8'h80;
    checkOut("R2");
    extClk = 1'b1; settle();
    shLdN = 1'b1; settle();                         // clock still high: no queued shift
    checkOut("R3");
    extClk = 1'b0; settle(); checkOut("R3");
    pulseClk(1'b0);
    checkOut("R3");
  endtask

  task automatic testLoadMidSequence();
    doLoad(8'h0F);
    for (int i = 0; i < 3; i++) pulseClk(1'b1);
    checkOut("R4");
    doLoad(8'hA3);
    checkOut("R2");
    for (int i = 0; i < WIDTH; i++) begin
      pulseClk(1'b0);
      checkOut("R2");
    end
  endtask

  task automatic testLatency();
    doLoad(8'h80);
    serIn = 1'b0;
    @(negedge clk); extClk = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    checkBit("R8", serOut, 1'b1);
    @(posedge clk); @(negedge clk);
    checkBit("R8", serOut, 1'b0);
    extClk = 1'b0; settle();
  endtask

  initial begin
    testReset();
    testLoadShift();
    testSerialFill();
    testInhibitEdge();
    testInhibitWhileHigh();
    testLoadOverride();
    testLoadMidSequence();
    testLatency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule